// File: doc/BRIEF.md
# Linear Chirp Sine Generator

This block produces a linear frequency sweep as a stream of signed sine samples, one per clock, for a downstream DAC. A phase accumulator adds a phase increment on every sample. A second accumulator moves that increment by a fixed, signed step on every sample. Because the increment changes linearly with time, the output frequency changes linearly too. A positive step gives a rising sweep and a negative step gives a falling one.

The top bits of the phase address a table that holds one quarter of a sine period. Folding logic mirrors the table address and negates the result, which rebuilds the full wave from that quarter. The table is computed at elaboration. The datapath is pipelined so that it can accept a new phase on every clock.

A single start pulse latches the start increment, the step and the sample count, then begins a new sweep. When the requested number of samples has been emitted, the block holds its output at zero and raises done.

Top module: `chirp_dds_top`

## Requirements
- R1: While reset is held and after it is released, sample_valid, sample and done are all 0.
- R2: A start pulse captured at clock edge E loads phase 0 and the start increment. The first sample of the sweep is valid directly after edge E+3.
- R3: Sample n of a sweep (n = 0, 1, …) has phase P(n) = n·I0 + S·n(n−1)/2 modulo 2^PHASE_W. Here I0 is the start increment and S is the step, read as a two's-complement number. Consecutive samples are valid on consecutive cycles, with no gaps.
- R4: The 12-bit index p is the top 12 bits of P(n). The output value is round-half-away-from-zero(A·sin(2π(p+0.5)/4096)), with A = 2^(SAMP_W−1)−1.
- R5: The top two phase bits q select the quadrant. When q[0] is 1, the 10-bit table index is replaced by its bitwise complement. When q[1] is 1, the table value is negated.
- R6: A sweep of length L emits exactly L valid samples. done rises in the same cycle as the last sample and stays high until the next start.
- R7: A sweep of length 0 emits no sample. done rises directly after edge E+3.
- R8: While sample_valid is 0, sample is 0.
- R9: A start during a running sweep aborts it. No sample of the aborted sweep appears after the new start, and done is cleared.
- R10: inc_init, inc_step and sweep_len are read only at start. Changing them during a sweep has no effect on its samples.
- R11: A negative step produces a falling sweep whose samples follow R3 with the sign of S applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-cycle pulse that starts or restarts a sweep |
| inc_init | input | PHASE_W | Phase increment for the first step |
| inc_step | input | PHASE_W | Two's-complement amount added to the increment after each sample |
| sweep_len | input | LEN_W | Number of samples in the sweep |
| sample_valid | output | 1 | High when sample carries a sweep sample |
| sample | output | SAMP_W | Signed sine sample, zero when idle |
| done | output | 1 | Sweep finished; held until the next start |

## Verification
The embedded assertions check four things on every cycle:
- start loads phase zero and the start increment.
- An active sample slot never has a zero remaining count.
- The output is zero whenever no sample is valid.
- done stays high until a start arrives, and a start flushes the output stage.

The values of the sine samples, the quadrant folding, the phase law across rising and falling sweeps, the exact three-cycle latency, the sample count and the time at which done rises can only be shown by the bench. Its scenarios replay random and directed sweeps and compare each sample with a closed-form phase and sine computation. These sweeps include a zero-length sweep, a restart in mid-sweep and inputs that change during a sweep.

// File: rtl/chirp_pkg.sv
// Shared types for the chirp generator.
// Assumes the quadrant is taken from the two top phase bits.
package chirp_pkg;
    typedef enum logic [1:0] {
        QD_RISE     = 2'b00,
        QD_FALL     = 2'b01,
        QD_NEG_RISE = 2'b10,
        QD_NEG_FALL = 2'b11
    } quadrant_e;
endpackage

// File: rtl/chirp_sweep_ctrl.sv
// Sweep controller with the phase and increment accumulators.
// On start it clears the phase, latches the increment, step and length, and
// then issues one phase per clock until the length is used up.
// Assumes start is a single-cycle pulse; a start always wins over a running sweep.
module chirp_sweep_ctrl #(
    parameter int PHASE_W = 32,
    parameter int LEN_W   = 16,
    parameter int TOP_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PHASE_W-1:0] inc_init,
    input  logic [PHASE_W-1:0] inc_step,
    input  logic [LEN_W-1:0]   sweep_len,
    output logic [TOP_W-1:0]   phase_top,
    output logic               tok_vld,
    output logic               tok_fin
);
    logic [PHASE_W-1:0] phase_r;
    logic [PHASE_W-1:0] inc_r;
    logic [PHASE_W-1:0] step_r;
    logic [LEN_W-1:0]   cnt_r;

    // Load on start, advance both accumulators while samples remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_r <= '0;
            inc_r   <= '0;
            step_r  <= '0;
            cnt_r   <= '0;
            tok_vld <= 1'b0;
            tok_fin <= 1'b0;
        end else if (start) begin
            phase_r <= '0;
            inc_r   <= inc_init;
            step_r  <= inc_step;
            cnt_r   <= sweep_len;
            tok_vld <= (sweep_len != '0);
            tok_fin <= (sweep_len <= LEN_W'(1));
        end else if (tok_vld && !tok_fin) begin
            phase_r <= phase_r + inc_r;
            inc_r   <= inc_r + step_r;
            cnt_r   <= cnt_r - 1'b1;
            tok_fin <= (cnt_r == LEN_W'(2));
        end else begin
            tok_vld <= 1'b0;
            tok_fin <= 1'b0;
        end
    end

    assign phase_top = phase_r[PHASE_W-1 -: TOP_W];

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phase_r == '0 && inc_r == $past(inc_init))); // R2
    AST_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_vld |-> (cnt_r != '0)); // R6
endmodule

// File: rtl/chirp_quarter_rom.sv
// Quarter-wave sine lookup with quadrant folding and an output stage.
// Stage 1 folds the address, stage 2 reads the table, stage 3 applies the
// sign and registers sample, valid and done. A start flushes all stages.
// Assumes the table index width is TOP_W-2 and that it is filled at elaboration.
module chirp_quarter_rom
    import chirp_pkg::*;
#(
    parameter int TOP_W  = 12,
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [TOP_W-1:0]         phase_top,
    input  logic                     tok_vld,
    input  logic                     tok_fin,
    output logic                     sample_valid,
    output logic signed [SAMP_W-1:0] sample,
    output logic                     done
);
    localparam int IDX_W = TOP_W - 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int MAG_W = SAMP_W - 1;

    // Rounded magnitude of the quarter-wave entry i, sampled at the bin centre.
    function automatic logic [MAG_W-1:0] quarter_val(input int i);
        real amp;
        real ang;
        amp = (2.0 ** MAG_W) - 1.0;
        ang = 3.14159265358979323846 * (real'(i) + 0.5) / (2.0 * real'(DEPTH));
        return MAG_W'($rtoi(amp * $sin(ang) + 0.5));
    endfunction

    logic [MAG_W-1:0] table_w [DEPTH];
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_table
        assign table_w[gi] = quarter_val(gi);
    end

    quadrant_e        quad;
    logic [IDX_W-1:0] idx_raw;
    logic [IDX_W-1:0] addr1;
    logic             neg1, vld1, fin1;
    logic [MAG_W-1:0] mag2;
    logic             neg2, vld2, fin2;

    assign quad    = quadrant_e'(phase_top[TOP_W-1 -: 2]);
    assign idx_raw = phase_top[IDX_W-1:0];

    // Stage 1: mirror the index in falling quadrants, note the sign.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            addr1 <= '0;
            neg1  <= 1'b0;
            vld1  <= 1'b0;
            fin1  <= 1'b0;
        end else begin
            addr1 <= (quad == QD_FALL || quad == QD_NEG_FALL) ? ~idx_raw : idx_raw;
            neg1  <= (quad == QD_NEG_RISE || quad == QD_NEG_FALL);
            vld1  <= tok_vld;
            fin1  <= tok_fin;
        end
    end

    // Stage 2: registered table read.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            mag2 <= '0;
            neg2 <= 1'b0;
            vld2 <= 1'b0;
            fin2 <= 1'b0;
        end else begin
            mag2 <= table_w[addr1];
            neg2 <= neg1;
            vld2 <= vld1;
            fin2 <= fin1;
        end
    end

    // Stage 3: apply sign, zero when idle, latch done.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            sample       <= '0;
            sample_valid <= 1'b0;
            done         <= 1'b0;
        end else begin
            sample       <= !vld2 ? '0 :
                            (neg2 ? -$signed({1'b0, mag2}) : $signed({1'b0, mag2}));
            sample_valid <= vld2;
            done         <= done | fin2;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> (sample == '0)); // R8
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R6
    AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!sample_valid && !done)); // R9
endmodule

// File: rtl/chirp_dds_top.sv
// Linear chirp generator top: sweep controller feeding the folded sine table.
// Assumes TOP_W = 12 phase bits address the wave (10-bit quarter table).
module chirp_dds_top #(
    parameter int PHASE_W = 32,
    parameter int LEN_W   = 16,
    parameter int SAMP_W  = 16,
    parameter int TOP_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [PHASE_W-1:0]       inc_init,
    input  logic [PHASE_W-1:0]       inc_step,
    input  logic [LEN_W-1:0]         sweep_len,
    output logic                     sample_valid,
    output logic signed [SAMP_W-1:0] sample,
    output logic                     done
);
    logic [TOP_W-1:0] phase_top;
    logic             tok_vld;
    logic             tok_fin;

    chirp_sweep_ctrl #(
        .PHASE_W (PHASE_W),
        .LEN_W   (LEN_W),
        .TOP_W   (TOP_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .inc_init  (inc_init),
        .inc_step  (inc_step),
        .sweep_len (sweep_len),
        .phase_top (phase_top),
        .tok_vld   (tok_vld),
        .tok_fin   (tok_fin)
    );

    chirp_quarter_rom #(
        .TOP_W  (TOP_W),
        .SAMP_W (SAMP_W)
    ) rom_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .phase_top    (phase_top),
        .tok_vld      (tok_vld),
        .tok_fin      (tok_fin),
        .sample_valid (sample_valid),
        .sample       (sample),
        .done         (done)
    );
endmodule

// File: tb/chirp_dds_top_tb.sv
// Self-checking bench: random and directed sweeps against a closed-form model.
module chirp_dds_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 32;
    localparam int LW = 16;
    localparam int SW = 16;
    localparam real PI = 3.14159265358979323846;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [PW-1:0]        inc_init = '0;
    logic [PW-1:0]        inc_step = '0;
    logic [LW-1:0]        sweep_len = '0;
    logic                 sample_valid;
    logic signed [SW-1:0] sample;
    logic                 done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    chirp_dds_top dut_i (
        .clk (clk), .rst_n (rst_n), .start (start),
        .inc_init (inc_init), .inc_step (inc_step), .sweep_len (sweep_len),
        .sample_valid (sample_valid), .sample (sample), .done (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [PW-1:0] exp_phase(input int n, input logic [PW-1:0] i0,
                                                input logic [PW-1:0] st);
        longint unsigned nn = longint'(n);
        longint unsigned t = nn * longint'(i0) + longint'(st) * ((nn * (nn - 1)) / 2);
        return t[PW-1:0];
    endfunction

    function automatic int exp_sample(input logic [PW-1:0] ph);
        int p = int'(ph[PW-1 -: 12]);
        real amp = (2.0 ** (SW - 1)) - 1.0;
        real v = amp * $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One sweep: pulse start, then compare every cycle against the model.
    task automatic run_sweep(input logic [PW-1:0] i0, input logic [PW-1:0] st,
                             input int len, input bit scramble, input string tag);
        int got = 0;
        int done_at = (len == 0) ? 3 : 2 + len;
        @(negedge clk);
        inc_init = i0; inc_step = st; sweep_len = LW'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin   // R10: inputs change after the start pulse
            inc_init = $urandom; inc_step = $urandom; sweep_len = LW'($urandom);
        end
        for (int c = 0; c < len + 8; c++) begin
            if (c > 0) @(negedge clk);
            if (sample_valid) begin
                // R2 latency, R3 back-to-back samples, R9 no stale samples
                check(c == 3 + got, {tag, " R3 sample slot"}, c, 3 + got);
                // R4 R5 R11 value from phase law and quadrant folding
                check(int'(sample) == exp_sample(exp_phase(got, i0, st)),
                      {tag, " R4 sample value"}, int'(sample),
                      exp_sample(exp_phase(got, i0, st)));
                got++;
            end else begin
                check(sample == '0, {tag, " R8 idle zero"}, int'(sample), 0);
            end
            // R6 R7 done timing
            check(done == (c >= done_at), {tag, " R6 done timing"}, int'(done),
                  int'(c >= done_at));
        end
        check(got == len, {tag, " R6 sample count"}, got, len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        summary();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1 reset state
        repeat (3) @(negedge clk);
        check(!sample_valid && sample == '0 && !done, "R1 in reset", int'(sample_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!sample_valid && sample == '0 && !done, "R1 after reset", int'(done), 0);

        // Directed: quarter-turn increment walks all quadrants (R5)
        run_sweep(32'h4000_0000 + 32'h0003_0000, 32'd0, 20, 0, "quad");
        // Directed: single sample and empty sweep (R7)
        run_sweep(32'h0123_4567, 32'h0000_1000, 1, 0, "len1");
        run_sweep(32'h0123_4567, 32'h0000_1000, 0, 0, "len0");
        // Directed: falling sweep (R11)
        run_sweep(32'h2000_0000, -32'sd65536, 120, 0, "fall");
        // Directed: rising sweep with inputs scrambled mid-sweep (R10)
        run_sweep(32'h0010_0000, 32'h0004_0000, 90, 1, "hold");
        // Directed: restart during a running sweep (R9)
        @(negedge clk);
        inc_init = 32'h0800_0000; inc_step = 32'h100; sweep_len = 16'd60; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        run_sweep(32'h0300_0000, 32'h0001_0000, 40, 0, "restart");
        // Random sweeps with signed steps
        for (int k = 0; k < 8; k++) begin
            logic [PW-1:0] st;
            st = PW'($urandom_range(0, 400000)) - PW'(200000);
            run_sweep($urandom, st, $urandom_range(1, 200), k[0], "rand");
        end
        // R6: done stays high while idle
        repeat (5) @(negedge clk);
        check(done && !sample_valid, "R6 done held", int'(done), 1);
        summary();
    end
endmodule